// File: doc/BRIEF.md
# Self-Clocking Stereo Serial Audio Transmitter

This block sends a stereo pair of 24-bit audio words over a single serial data line in standard I2S framing. It works only as a follower. The host supplies a fast master clock and a left/right frame clock. The block never drives either clock. The block counts master-clock cycles over each full frame and works out from that count whether the master clock runs at 256 or 128 times the sample rate. It then derives an internal bit clock at 64 times the sample rate and shifts the words out. No configuration is needed: the clocks alone set the mode.

Audio pairs enter through a valid/ready stream port. One pair is held in a single-entry holding register. While `s_ready` is high, a pair is taken on any clock where `s_valid` is also high. `s_ready` then stays low until the held pair moves into the transmit registers at the start of the next left half-frame. A producer must keep `s_valid` and the data steady until the transfer happens. If no pair is waiting when a left half-frame starts, the frame is sent as zeros. Two status flags report whether the block is locked to a supported ratio and whether the measured frame length is unsupported.

Top module: `i2s_autoratio_tx`

## Requirements
- R1: While reset is held, `ser_out`, `locked_o` and `bad_ratio_o` are low and `s_ready` is high.
- R2: The frame length is measured in master-clock cycles between synchronized rising edges of `frame_clk`. A length of 256 gives a bit period of 4 master cycles, and a length of 128 gives a bit period of 2 master cycles.
- R3: `locked_o` goes high one cycle after a rising frame edge whose measured length matches the previous frame's supported length. It stays high while later frames keep measuring that same length.
- R4: A measured frame length other than 128 or 256 sets `bad_ratio_o`, clears `locked_o`, and holds `ser_out` low from then on. A following supported measurement clears `bad_ratio_o`.
- R5: Each half-frame is split into 32 bit periods, counted from the synchronized `frame_clk` transition. The word's MSB goes out in bit period 1, and the remaining bits follow in order down to the LSB in bit period 24.
- R6: `ser_out` is low in bit period 0 and in bit periods 25 to 31.
- R7: `frame_clk` low selects the left word and `frame_clk` high selects the right word.
- R8: `ser_out` changes only at the start of a bit period, which is the falling edge of the internal bit clock. It arrives one master cycle after the synchronized transition is seen.
- R9: `s_ready` is high exactly when the holding register is empty. A pair is taken on `s_valid && s_ready`. While the block is locked, the held pair moves to the transmit registers at the start of each left half-frame, and this frees the holding register.
- R10: A left half-frame that starts with an empty holding register sends zero for both words of that frame.
- R11: If no rising edge of `frame_clk` is seen for 512 master cycles, the block raises `bad_ratio_o` and clears `locked_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_master | input | 1 | Master clock; the whole block runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clk | input | 1 | Host left/right frame clock, asynchronous |
| s_valid | input | 1 | Stereo pair on `s_left`/`s_right` is offered |
| s_ready | output | 1 | Holding register is empty and can take a pair |
| s_left | input | 24 | Left-channel word |
| s_right | input | 24 | Right-channel word |
| ser_out | output | 1 | Serial audio data |
| locked_o | output | 1 | Two consecutive frames measured the same supported ratio |
| bad_ratio_o | output | 1 | Last measurement was unsupported or the frame clock stalled |

## Verification
The bench drives several frame clocks in turn: 256-cycle frames, then 128-cycle frames, then 200-cycle frames, then 256-cycle frames again, then a frame clock held still, then a final recovery. This tells apart the two bit-period widths, relocking after a ratio change, the unsupported-length path and the stall path. The words include single-bit-set values at the top and bottom, all-ones, alternating patterns, and a different right word for each left word. These show the bit order, the slot position and whether left and right are swapped. A stretch where the producer stops offering data shows the zero frames sent on underrun and how `s_ready` behaves around the left-frame handover.

// File: rtl/i2s_art_pkg.sv
package i2s_art_pkg;
  typedef enum logic [1:0] {
    RATE_NONE = 2'd0,
    RATE_LO   = 2'd1,
    RATE_HI   = 2'd2,
    RATE_BAD  = 2'd3
  } rate_e;
endpackage

// File: rtl/art_frame_sync.sv
module art_frame_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lr_async,
  output logic lr_o,
  output logic edge_o,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], lr_async};
  end

  assign lr_o   = chain[STAGES-1];
  assign edge_o = chain[STAGES-1] ^ chain[STAGES];
  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/art_ratio_meter.sv
module art_ratio_meter
  import i2s_art_pkg::*;
#(
  parameter int LO_RATIO = 128,
  parameter int HI_RATIO = 256
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise_i,
  output logic  locked_o,
  output logic  bad_o,
  output rate_e rate_o
);
  localparam int CNT_W = $clog2(2 * HI_RATIO);
  localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(HI_RATIO - 1);
  localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(LO_RATIO - 1);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  rate_e            prev_q;
  rate_e            meas;

  always_comb begin
    if (cnt_q == CNT_HI)      meas = RATE_HI;
    else if (cnt_q == CNT_LO) meas = RATE_LO;
    else                      meas = RATE_BAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      seen_q   <= 1'b0;
      prev_q   <= RATE_NONE;
      locked_o <= 1'b0;
      bad_o    <= 1'b0;
      rate_o   <= RATE_NONE;
    end else if (rise_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b1;
      if (seen_q) begin
        if (meas == RATE_BAD) begin
          bad_o    <= 1'b1;
          locked_o <= 1'b0;
          prev_q   <= RATE_BAD;
        end else begin
          bad_o  <= 1'b0;
          prev_q <= meas;
          if (prev_q == meas) begin
            locked_o <= 1'b1;
            rate_o   <= meas;
          end else begin
            locked_o <= 1'b0;
          end
        end
      end
    end else if (cnt_q == CNT_SAT) begin
      bad_o    <= 1'b1;
      locked_o <= 1'b0;
      prev_q   <= RATE_BAD;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_LOCK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(rise_i)); // R3
  AST_LOCK_NOT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> !bad_o); // R4
endmodule

// File: rtl/art_pair_buffer.sv
module art_pair_buffer #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_left,
  input  logic [WORD_W-1:0] s_right,
  input  logic              take_i,
  output logic [WORD_W-1:0] act_l_o,
  output logic [WORD_W-1:0] act_r_o
);
  logic [WORD_W-1:0] pend_l, pend_r;
  logic              full_q;
  logic              acc;

  assign s_ready = ~full_q;
  assign acc     = s_valid & ~full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l  <= '0;
      pend_r  <= '0;
      full_q  <= 1'b0;
      act_l_o <= '0;
      act_r_o <= '0;
    end else begin
      if (take_i) begin
        act_l_o <= full_q ? pend_l : '0;
        act_r_o <= full_q ? pend_r : '0;
        full_q  <= 1'b0;
      end
      if (acc) begin
        pend_l <= s_left;
        pend_r <= s_right;
        full_q <= 1'b1;
      end
    end
  end

  AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready); // R9
endmodule

// File: rtl/art_serializer.sv
module art_serializer
  import i2s_art_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int LO_RATIO = 128,
  parameter int HI_RATIO = 256,
  parameter int BIT_MUL  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_i,
  input  logic              edge_i,
  input  logic              locked_i,
  input  rate_e             rate_i,
  input  logic [WORD_W-1:0] act_l_i,
  input  logic [WORD_W-1:0] act_r_i,
  output logic              take_o,
  output logic              ser_o
);
  localparam int HI_SH = $clog2(HI_RATIO / BIT_MUL);
  localparam int LO_SH = $clog2(LO_RATIO / BIT_MUL);
  localparam int POS_W = $clog2(HI_RATIO);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0]  pos_q, cur, slot;
  logic [WORD_W-1:0] word;
  logic              bit_d;

  assign cur    = edge_i ? '0 : pos_q;
  assign slot   = (rate_i == RATE_HI) ? (cur >> HI_SH) : (cur >> LO_SH);
  assign word   = lr_i ? act_r_i : act_l_i;
  assign take_o = edge_i & ~lr_i & locked_i;

  // bit period k (1..WORD_W) carries word bit WORD_W-k; all others are low
  always_comb begin
    bit_d = 1'b0;
    for (int k = 0; k < WORD_W; k++)
      if (slot == POS_W'(WORD_W - k)) bit_d = word[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      ser_o <= 1'b0;
    end else begin
      pos_q <= edge_i ? POS_W'(1) : ((pos_q == POS_MAX) ? pos_q : pos_q + 1'b1);
      ser_o <= locked_i & bit_d;
    end
  end

  AST_SILENT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_i |=> !ser_o); // R4
  AST_SLOT0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> !ser_o); // R6
endmodule

// File: rtl/i2s_autoratio_tx.sv
module i2s_autoratio_tx
  import i2s_art_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int LO_RATIO    = 128,
  parameter int HI_RATIO    = 256,
  parameter int BIT_MUL     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_master,
  input  logic              rst_n,
  input  logic              frame_clk,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_left,
  input  logic [WORD_W-1:0] s_right,
  output logic              ser_out,
  output logic              locked_o,
  output logic              bad_ratio_o
);
  logic              lr_s, lr_edge, lr_rise, take;
  rate_e             rate;
  logic [WORD_W-1:0] act_l, act_r;

  art_frame_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk_master), .rst_n(rst_n), .lr_async(frame_clk),
    .lr_o(lr_s), .edge_o(lr_edge), .rise_o(lr_rise)
  );

  art_ratio_meter #(.LO_RATIO(LO_RATIO), .HI_RATIO(HI_RATIO)) i_meter (
    .clk(clk_master), .rst_n(rst_n), .rise_i(lr_rise),
    .locked_o(locked_o), .bad_o(bad_ratio_o), .rate_o(rate)
  );

  art_pair_buffer #(.WORD_W(WORD_W)) i_buf (
    .clk(clk_master), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .take_i(take),
    .act_l_o(act_l), .act_r_o(act_r)
  );

  art_serializer #(.WORD_W(WORD_W), .LO_RATIO(LO_RATIO), .HI_RATIO(HI_RATIO),
                   .BIT_MUL(BIT_MUL)) i_ser (
    .clk(clk_master), .rst_n(rst_n), .lr_i(lr_s), .edge_i(lr_edge),
    .locked_i(locked_o), .rate_i(rate), .act_l_i(act_l), .act_r_i(act_r),
    .take_o(take), .ser_o(ser_out)
  );
endmodule

// File: tb/test_i2s_autoratio_tx.sv
module test_i2s_autoratio_tx;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0, rst_n = 1'b0, frame_clk = 1'b0, s_valid = 1'b0;
  logic [23:0] s_left = '0, s_right = '0;
  logic        s_ready, ser_out, locked_o, bad_ratio_o;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int half_len = 0, lr_cnt = 0, feed_idx = 0;
  bit feed_en = 1'b0;

  // reference model state
  int q1 = 0, q2 = 0, q3 = 0;
  int m_pos = 0, m_rate = 0, m_cnt = 0, m_prev = 0;
  bit m_seen = 0, m_lock = 0, m_bad = 0, m_full = 0, m_acc = 0, e_ser = 0;
  logic [23:0] m_pend_l = '0, m_pend_r = '0, m_act_l = '0, m_act_r = '0;

  i2s_autoratio_tx i_i2s_autoratio_tx (
    .clk_master(clk), .rst_n(rst_n), .frame_clk(frame_clk),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .ser_out(ser_out), .locked_o(locked_o), .bad_ratio_o(bad_ratio_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] pat_l(int i);
    case (i % 6)
      0: return 24'h800001;
      1: return 24'hFFFFFF;
      2: return 24'h000001;
      3: return 24'hA5C3E1;
      4: return 24'h7FFFFE;
      default: return 24'(i * 24'h01F3B7);
    endcase
  endfunction

  function automatic logic [23:0] pat_r(int i);
    logic [23:0] l = pat_l(i);
    return {l[11:0], l[23:12]} ^ 24'h0F0F0F;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: frame-clock history, frame measurement, slot position
  always @(posedge clk) begin
    int a, b, cur, dv, slot, meas;
    bit edge_s, rise_s, take;
    logic [23:0] word;
    cyc++;
    if (!rst_n) begin
      q1 = 0; q2 = 0; q3 = 0; m_pos = 0; m_rate = 0; m_cnt = 0; m_prev = 0;
      m_seen = 0; m_lock = 0; m_bad = 0; m_full = 0; m_acc = 0; e_ser = 0;
      m_pend_l = '0; m_pend_r = '0; m_act_l = '0; m_act_r = '0;
    end else begin
      a = q2; b = q3;
      q3 = q2; q2 = q1; q1 = int'(frame_clk);
      edge_s = (a != b);
      rise_s = (a == 1) && (b == 0);
      cur  = edge_s ? 0 : m_pos;
      dv   = (m_rate == 256) ? 4 : 2;
      slot = cur / dv;
      word = (a == 1) ? m_act_r : m_act_l;
      e_ser = (m_lock && slot >= 1 && slot <= 24) ? word[24 - slot] : 1'b0;
      m_pos = edge_s ? 1 : ((m_pos < 255) ? m_pos + 1 : 255);
      take  = edge_s && (a == 0) && m_lock;
      m_acc = s_valid && !m_full;
      if (take) begin
        m_act_l = m_full ? m_pend_l : '0;
        m_act_r = m_full ? m_pend_r : '0;
        m_full  = 0;
      end
      if (m_acc) begin
        m_pend_l = s_left; m_pend_r = s_right; m_full = 1;
      end
      if (rise_s) begin
        if (m_seen) begin
          meas = (m_cnt == 255) ? 256 : ((m_cnt == 127) ? 128 : -1);
          if (meas < 0) begin
            m_bad = 1; m_lock = 0; m_prev = -1;
          end else begin
            m_bad = 0;
            if (m_prev == meas) begin m_lock = 1; m_rate = meas; end
            else m_lock = 0;
            m_prev = meas;
          end
        end
        m_cnt = 0; m_seen = 1;
      end else if (m_cnt == 511) begin
        m_bad = 1; m_lock = 0; m_prev = -1;
      end else begin
        m_cnt++;
      end
    end
  end

  // compare and drive away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5 R6 R7 R8 R10 ser_out", int'(ser_out), int'(e_ser));
      check("R3 locked_o", int'(locked_o), int'(m_lock));
      check("R4 bad_ratio_o", int'(bad_ratio_o), int'(m_bad));
      check("R9 s_ready", int'(s_ready), int'(!m_full));
      if (half_len > 0) begin
        lr_cnt++;
        if (lr_cnt >= half_len) begin lr_cnt = 0; frame_clk = ~frame_clk; end
      end
      if (m_acc) begin feed_idx++; s_valid = 1'b0; end
      if (feed_en && !s_valid) begin
        s_valid = 1'b1;
        s_left  = pat_l(feed_idx);
        s_right = pat_r(feed_idx);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset ser_out", int'(ser_out), 0);
    check("R1 reset locked_o", int'(locked_o), 0);
    check("R1 reset bad_ratio_o", int'(bad_ratio_o), 0);
    check("R1 reset s_ready", int'(s_ready), 1);
    rst_n = 1'b1;
    feed_en = 1'b1;
    half_len = 128;
    repeat (2600) @(negedge clk);
    check("R2 R3 locked at ratio 256", int'(locked_o), 1);
    half_len = 64;
    repeat (1400) @(negedge clk);
    check("R2 R3 relocked at ratio 128", int'(locked_o), 1);
    check("R2 no bad flag at ratio 128", int'(bad_ratio_o), 0);
    half_len = 100;
    repeat (1400) @(negedge clk);
    check("R4 bad flag on 200-cycle frame", int'(bad_ratio_o), 1);
    check("R4 unlocked on 200-cycle frame", int'(locked_o), 0);
    half_len = 128;
    repeat (1200) @(negedge clk);
    check("R4 bad flag cleared by good frame", int'(bad_ratio_o), 0);
    feed_en = 1'b0;
    repeat (1200) @(negedge clk);
    check("R10 holding register drained", int'(s_ready), 1);
    half_len = 0;
    repeat (700) @(negedge clk);
    check("R11 stall raises bad flag", int'(bad_ratio_o), 1);
    check("R11 stall clears lock", int'(locked_o), 0);
    half_len = 128;
    feed_en = 1'b1;
    repeat (1200) @(negedge clk);
    check("R3 relock after stall", int'(locked_o), 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule